// File: doc/BRIEF.md
# Flash Read Wait-State Sequencer

This block paces reads from a slow memory array. A requester presents an address together with a flag that marks it as belonging to the special region, which holds the trim and engineering sectors. The block accepts the request and drives the latched address to the array. It then waits for a programmed number of wait states before it registers the array word and raises a one-cycle response strobe.

Two 4-bit wait-state settings are kept, one for the special region and one for every other address. Each setting resets to 2 and can be rewritten only while its own lock input is low. A setting of zero is not a legal latency, so the block treats it as one wait state. The setting in force is captured when a request is accepted, so reprogramming never disturbs an access that is already in flight.

Top module: `flash_wait_seq`

## Requirements
- R1: After reset the block shows `req_ready`=1, `rsp_valid`=0 and `rsp_data`=0.
- R2: Both settings reset to 2, so an access in either region completes in 3 cycles. Latency is counted from the clock edge that accepts the request to the edge that raises `rsp_valid`.
- R3: When `req_special`=0 at acceptance, the latency equals the main setting plus 1.
- R4: When `req_special`=1 at acceptance, the latency equals the special setting plus 1, whatever the main setting holds.
- R5: A setting of 0 behaves as 1, giving a latency of 2, which is the minimum.
- R6: A write on the configuration port updates the main setting when `cfg_region`=0 and the special setting when `cfg_region`=1. It is ignored while the matching lock input (`lock_main` or `lock_special`) is 1. The other region's lock has no effect on it.
- R7: An access uses the setting held when it is accepted. A write in the same cycle as acceptance, or during the access, takes effect from the next access.
- R8: `req_ready` is 0 from the accepting edge through the cycle in which `rsp_valid` is 1, and it is 1 again in the following cycle. A request presented while `req_ready`=0 is ignored and produces no response.
- R9: `rsp_valid` is a single-cycle pulse. `rsp_data` carries the array word at the accepted address and holds its value until the next response.
- R10: The largest setting, 15, gives a latency of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 1 | Setting to write: 0 main, 1 special |
| cfg_wdata | input | WSW (4) | New wait-state value |
| lock_main | input | 1 | Blocks writes to the main setting |
| lock_special | input | 1 | Blocks writes to the special setting |
| req_valid | input | 1 | Read request present |
| req_special | input | 1 | Request targets the special region |
| req_addr | input | AW (16) | Read address |
| req_ready | output | 1 | Block can accept a request |
| arr_addr | output | AW (16) | Address held toward the array |
| arr_rdata | input | DW (32) | Array word for `arr_addr` |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW (32) | Registered read data |

## Verification
Two events can fall in the same cycle: a configuration write and the acceptance of a request. The bench drives the write strobe and the request on the same clock edge. It then expects that access to finish with the old latency and the next access in the same region to finish with the new one. A second case issues a write in the middle of a long access, and the scoreboard measures every response's latency in edges from its accepting edge.

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic {
        RGN_MAIN    = 1'b0,
        RGN_SPECIAL = 1'b1
    } region_e;

    localparam int unsigned NUM_RGN = 2;
endpackage

// File: rtl/fws_cfg_reg.sv
module fws_cfg_reg #(
    parameter int unsigned WSW     = 4,
    parameter int unsigned RST_VAL = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           lock,
    input  logic [WSW-1:0] wr_data,
    output logic [WSW-1:0] val
);
    logic [WSW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en && !lock) begin
            val_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= WSW'(RST_VAL);
        end else begin
            val_q <= val_d;
        end
    end

    assign val = val_q;
endmodule

// File: rtl/fws_lat_sel.sv
module fws_lat_sel #(
    parameter int unsigned WSW = 4
) (
    input  logic           special,
    input  logic [WSW-1:0] main_val,
    input  logic [WSW-1:0] spec_val,
    output logic [WSW-1:0] lat
);
    logic [WSW-1:0] picked;

    always_comb begin
        picked = special ? spec_val : main_val;
        // zero wait states are not legal; run with one instead
        lat    = (picked == '0) ? WSW'(1) : picked;
    end
endmodule

// File: rtl/fws_seq.sv
module fws_seq #(
    parameter int unsigned AW  = 16,
    parameter int unsigned DW  = 32,
    parameter int unsigned WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [WSW-1:0] lat,
    output logic           req_ready,
    output logic [AW-1:0]  arr_addr,
    input  logic [DW-1:0]  arr_rdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data
);
    typedef struct packed {
        logic           busy;
        logic [WSW-1:0] cnt;
        logic [AW-1:0]  addr;
        logic           vld;
        logic [DW-1:0]  data;
    } seq_t;

    seq_t st_d, st_q;
    logic ready_w;

    always_comb begin
        ready_w = !st_q.busy && !st_q.vld;
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
                st_d.data = arr_rdata;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_valid && ready_w) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat;
            st_d.addr = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = ready_w;
    assign arr_addr  = st_q.addr;
    assign rsp_valid = st_q.vld;
    assign rsp_data  = st_q.data;
endmodule

// File: rtl/flash_wait_seq.sv
module flash_wait_seq
    import fws_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 32,
    parameter int unsigned WSW      = 4,
    parameter int unsigned WAIT_RST = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_region,
    input  logic [WSW-1:0] cfg_wdata,
    input  logic           lock_main,
    input  logic           lock_special,
    input  logic           req_valid,
    input  logic           req_special,
    input  logic [AW-1:0]  req_addr,
    output logic           req_ready,
    output logic [AW-1:0]  arr_addr,
    input  logic [DW-1:0]  arr_rdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data
);
    logic [NUM_RGN-1:0] lock_vec;
    logic [WSW-1:0]     wait_set [NUM_RGN];
    logic [WSW-1:0]     lat_w;

    always_comb begin
        lock_vec                   = '0;
        lock_vec[int'(RGN_MAIN)]    = lock_main;
        lock_vec[int'(RGN_SPECIAL)] = lock_special;
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        fws_cfg_reg #(
            .WSW     (WSW),
            .RST_VAL (WAIT_RST)
        ) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_region == 1'(g))),
            .lock    (lock_vec[g]),
            .wr_data (cfg_wdata),
            .val     (wait_set[g])
        );
    end

    fws_lat_sel #(.WSW(WSW)) u_sel (
        .special  (req_special),
        .main_val (wait_set[int'(RGN_MAIN)]),
        .spec_val (wait_set[int'(RGN_SPECIAL)]),
        .lat      (lat_w)
    );

    fws_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .lat       (lat_w),
        .req_ready (req_ready),
        .arr_addr  (arr_addr),
        .arr_rdata (arr_rdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/flash_wait_seq_chk.sv
module flash_wait_seq_chk #(
    parameter int unsigned DW  = 32,
    parameter int unsigned WSW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic [DW-1:0]  rsp_data,
    input logic           lock_main,
    input logic           lock_special,
    input logic [WSW-1:0] wait_main,
    input logic [WSW-1:0] wait_spec
);
    localparam int unsigned CW      = WSW + 2;
    localparam int unsigned LAT_MAX = 1 << WSW;

    logic [CW-1:0] since_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= '0;
        end else if (req_valid && req_ready) begin
            since_acc <= '0;
        end else if (since_acc != '1) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));

    p_ready_low_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_busy_after_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // latency window: minimum from R5, maximum from R10
    p_lat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (since_acc >= CW'(2) && since_acc <= CW'(LAT_MAX)));

    p_lock_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_main |=> $stable(wait_main));

    p_lock_spec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_special |=> $stable(wait_spec));
endmodule

bind flash_wait_seq flash_wait_seq_chk #(.DW(DW), .WSW(WSW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .lock_main    (lock_main),
    .lock_special (lock_special),
    .wait_main    (wait_set[0]),
    .wait_spec    (wait_set[1])
);

// File: tb/flash_wait_seq_bench.sv
`timescale 1ns/1ps
module flash_wait_seq_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WSW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic           cfg_region = 1'b0;
    logic [WSW-1:0] cfg_wdata = '0;
    logic           lock_main = 1'b0;
    logic           lock_special = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_special = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic           req_ready;
    logic [AW-1:0]  arr_addr;
    logic [DW-1:0]  arr_rdata;
    logic           rsp_valid;
    logic [DW-1:0]  rsp_data;

    always #2 clk = ~clk;

    // array model: combinational lookup
    assign arr_rdata = {arr_addr ^ 16'hA5C3, arr_addr};

    flash_wait_seq u_flash_wait_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_wdata(cfg_wdata), .lock_main(lock_main), .lock_special(lock_special),
        .req_valid(req_valid), .req_special(req_special), .req_addr(req_addr),
        .req_ready(req_ready), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    typedef struct {
        logic [DW-1:0] data;
        int            lat;
        int            acc;
        string         tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int model_main = 2;
    int model_spec = 2;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    function automatic int exp_lat(input bit sp);
        int s;
        s = sp ? model_spec : model_main;
        if (s == 0) s = 1;
        return s + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: issue one request; optionally a config write on the same edge
    task automatic issue(input logic [AW-1:0] a, input bit sp, input string tag,
                         input bit with_cfg, input bit rgn, input int val);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_special = sp;
        it.data = exp_word(a);
        it.lat  = exp_lat(sp);
        it.acc  = cyc + 1;
        it.tag  = tag;
        q.push_back(it);
        if (with_cfg) begin
            cfg_we     = 1'b1;
            cfg_region = rgn;
            cfg_wdata  = WSW'(val);
            if (!rgn && !lock_main) model_main = val;
            if (rgn && !lock_special) model_spec = val;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        chk(req_ready == 1'b0, "R8 ready after accept", req_ready, 0);
    endtask

    task automatic cfg_write(input bit rgn, input int val);
        @(negedge clk);
        cfg_we     = 1'b1;
        cfg_region = rgn;
        cfg_wdata  = WSW'(val);
        if (!rgn && !lock_main) model_main = val;
        if (rgn && !lock_special) model_spec = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    bit prev_vld = 1'b0;
    logic [DW-1:0] last_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                item_t it;
                chk(!prev_vld, "R9 pulse width", prev_vld, 0);
                chk(req_ready == 1'b0, "R8 ready during response", req_ready, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", rsp_data, 0);
                end else begin
                    it = q.pop_front();
                    chk(rsp_data == it.data, {"R9 data ", it.tag}, rsp_data, it.data);
                    chk((cyc - it.acc) == it.lat, {"latency ", it.tag}, cyc - it.acc, it.lat);
                end
            end else begin
                chk(rsp_data == last_data, "R9 data hold", rsp_data, last_data);
                if (prev_vld) chk(req_ready == 1'b1, "R8 ready after response", req_ready, 1);
            end
            prev_vld  = rsp_valid;
            last_data = rsp_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && rsp_data == '0, "R1 reset state",
            {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after release", {req_ready, rsp_valid}, 2'b10);

        // R2 defaults
        issue(16'h0010, 1'b0, "R2 main default", 1'b0, 1'b0, 0);
        issue(16'h0020, 1'b1, "R2 special default", 1'b0, 1'b0, 0);
        drain();

        // R3 / R4 independent settings
        cfg_write(1'b0, 5);
        issue(16'h1234, 1'b0, "R3 main=5", 1'b0, 1'b0, 0);
        issue(16'h1235, 1'b1, "R4 special unaffected", 1'b0, 1'b0, 0);
        cfg_write(1'b1, 9);
        issue(16'h4001, 1'b1, "R4 special=9", 1'b0, 1'b0, 0);
        issue(16'h4002, 1'b0, "R3 main stays 5", 1'b0, 1'b0, 0);
        drain();

        // R5 zero treated as one
        cfg_write(1'b0, 0);
        cfg_write(1'b1, 0);
        issue(16'h0BAD, 1'b0, "R5 main zero", 1'b0, 1'b0, 0);
        issue(16'h0BAE, 1'b1, "R5 special zero", 1'b0, 1'b0, 0);
        cfg_write(1'b0, 1);
        issue(16'h0BAF, 1'b0, "R5 main one", 1'b0, 1'b0, 0);
        drain();

        // R10 maximum
        cfg_write(1'b0, 15);
        issue(16'hFFFF, 1'b0, "R10 main max", 1'b0, 1'b0, 0);
        cfg_write(1'b1, 15);
        issue(16'h8000, 1'b1, "R10 special max", 1'b0, 1'b0, 0);
        drain();

        // R6 locks
        lock_main = 1'b1;
        cfg_write(1'b0, 4);
        issue(16'h2222, 1'b0, "R6 main write locked", 1'b0, 1'b0, 0);
        cfg_write(1'b1, 4);
        issue(16'h2223, 1'b1, "R6 special free under main lock", 1'b0, 1'b0, 0);
        lock_special = 1'b1;
        cfg_write(1'b1, 7);
        issue(16'h2224, 1'b1, "R6 special write locked", 1'b0, 1'b0, 0);
        lock_main    = 1'b0;
        lock_special = 1'b0;
        cfg_write(1'b0, 3);
        issue(16'h2225, 1'b0, "R6 main after unlock", 1'b0, 1'b0, 0);
        drain();

        // R7 write on the accepting edge, then write during flight
        issue(16'h3000, 1'b0, "R7 same-edge old value", 1'b1, 1'b0, 12);
        issue(16'h3001, 1'b0, "R7 new value next access", 1'b0, 1'b0, 0);
        cfg_write(1'b0, 6);
        drain();
        issue(16'h3002, 1'b0, "R7 after mid-flight write", 1'b0, 1'b0, 0);
        issue(16'h3003, 1'b1, "R7 special same-edge", 1'b1, 1'b1, 2);
        issue(16'h3004, 1'b1, "R7 special next", 1'b0, 1'b0, 0);
        drain();

        // R8 requests while busy are ignored
        issue(16'h5000, 1'b0, "R8 base access", 1'b0, 1'b0, 0);
        req_valid = 1'b1;
        req_addr  = 16'hDEAD;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        chk(q.size() == 0, "R8 scoreboard empty", q.size(), 0);
        chk(rsp_data == exp_word(16'h5000), "R8 no extra response", rsp_data, exp_word(16'h5000));

        finish_run();
    end
endmodule